// File: doc/BRIEF.md
# Instruction Operand Decoder and Resolver

This block takes one 16-bit instruction word and turns it into everything an execute stage needs to know about its operands. It splits the word into an opcode and two operand fields, a destination field (b, 5 bits) and a source field (a, 6 bits). For each field it produces a descriptor with three kinds: a register selection with its current value, a memory address, or an immediate value. It also says whether the destination can be written. Along the way it applies the stack-pointer side effects of the push, pop and stack-relative codes. When an operand needs the word that follows the instruction, the block requests it through a small request/valid handshake and advances the program counter.

A controller pulses `start` with the instruction word and snapshots of the eight general registers, the stack pointer, the program counter and the excess register. The block resolves the source operand first and then the destination, so the destination sees the stack pointer as the source left it. When it is finished, `done` pulses for one cycle. The descriptors, the final stack pointer and the final program counter are then valid, and they hold until the next `start`. An opcode of zero marks a special instruction. For it, the destination field is reported as a special opcode and only the source operand is resolved. The arithmetic itself and the memory arrays belong to other blocks.

Top module: `opd_resolver`

## Requirements
- R1: The opcode output is word bits 4:0; the b code is bits 9:5 and the a code is bits 15:10 of the word latched at `start`, and later changes of `instr` have no effect on that instruction.
- R2: An opcode of 0 sets `is_special`, drives `spec_op` with the b code, clears `b_used` and leaves the b descriptor zero. `spec_known` is 1 exactly for special codes 0x01, 0x08 to 0x0C and 0x10 to 0x12.
- R3: Codes 0x00 to 0x07 give kind 0 (register), with select equal to the code (A, B, C, X, Y, Z, I, J in order) and value equal to that register. Codes 0x08 to 0x0F give kind 1 (memory), with the address equal to register (code−8). Register and memory kinds are writable.
- R4: Codes 0x10 to 0x17 give memory at next word + register (code−0x10), modulo 2^16. Code 0x1E gives memory at the next word. Code 0x1F gives kind 2 (immediate) holding the next word, with the write flag 0, so a write to it is discarded.
- R5: Code 0x18 in b is a push: the stack pointer is decremented first and the address is the new value. In a it is a pop: the address is the old stack pointer, which is then incremented. Both wrap modulo 2^16.
- R6: Code 0x19 gives memory at SP. Code 0x1A gives memory at SP + next word. Codes 0x1B, 0x1C and 0x1D give kind 0 with select 8, 9 and 10 and the value of SP, PC and EX.
- R7: a codes 0x20 to 0x3F give kind 2 with value (code − 0x21) mod 2^16, so 0xFFFF, 0, 1 … 30, and the write flag 0.
- R8: The a operand is resolved before b. When both need a next word, a's word is fetched first. Each fetch reads from address `pc` and advances `pc_out` by one. The b stack effects and the b value of PC see the state that a left.
- R9: `done` pulses for exactly one cycle per instruction. `nw_req` is never high with `done`. A `start` while an instruction is in progress is ignored.
- R10: After reset, `done` and `nw_req` are 0, and `sp_out` and `pc_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin decoding `instr` (accepted when idle) |
| instr | input | 16 | Instruction word |
| regs_flat | input | 128 | Eight 16-bit registers, A in bits 15:0 up to J in bits 127:112 |
| sp_in | input | 16 | Stack pointer at start |
| pc_in | input | 16 | Address of the word after the instruction |
| ex_in | input | 16 | Excess register value |
| nw_data | input | 16 | Next-word data |
| nw_valid | input | 1 | Next-word data valid this cycle |
| nw_req | output | 1 | Next-word fetch request |
| nw_addr | output | 16 | Address of the requested next word |
| done | output | 1 | One-cycle pulse: results valid |
| opcode | output | 5 | Opcode field |
| is_special | output | 1 | Opcode is zero |
| spec_op | output | 5 | Special opcode (b field) |
| spec_known | output | 1 | Special opcode is a defined one |
| a_kind | output | 2 | a kind: 0 register, 1 memory, 2 immediate |
| a_sel | output | 4 | a register select (0-7 general, 8 SP, 9 PC, 10 EX) |
| a_addr | output | 16 | a memory address |
| a_value | output | 16 | a register or immediate value |
| a_wr | output | 1 | a is writable |
| b_used | output | 1 | b operand present |
| b_kind | output | 2 | b kind |
| b_sel | output | 4 | b register select |
| b_addr | output | 16 | b memory address |
| b_value | output | 16 | b register or immediate value |
| b_wr | output | 1 | b is writable |
| sp_out | output | 16 | Stack pointer after side effects |
| pc_out | output | 16 | Program counter after fetches |

## Verification
On every cycle, the assertions check the step rules that hold for any instruction. The stack pointer moves by at most one per cycle. The program counter moves only on an accepted fetch, and by exactly one when it does. `done` is a single-cycle pulse that never coincides with a fetch request, and an immediate operand is never reported as writable. Only the bench's scenarios can show the values themselves. These are the address and value produced for each of the 64 a codes and 32 b codes, the push and pop wraparound at 0x0000 and 0xFFFF, the order of two fetches within one instruction, the handling of special opcodes, and the fact that a `start` pulse mid-instruction is ignored.

// File: rtl/opd_pkg.sv
package opd_pkg;
    localparam int WORD_W  = 16;
    localparam int NREG    = 8;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int OP_W    = 5;
    localparam int BCODE_W = 5;
    localparam int ACODE_W = 6;
    localparam int SEL_W   = 4;

    localparam logic [SEL_W-1:0] SEL_SP = 4'd8;
    localparam logic [SEL_W-1:0] SEL_PC = 4'd9;
    localparam logic [SEL_W-1:0] SEL_EX = 4'd10;

    typedef enum logic [1:0] {
        K_REG = 2'd0,
        K_MEM = 2'd1,
        K_IMM = 2'd2
    } opd_kind_e;

    typedef struct packed {
        opd_kind_e          kind;
        logic [SEL_W-1:0]   sel;
        logic [WORD_W-1:0]  addr;
        logic [WORD_W-1:0]  value;
        logic               wr;
    } opd_desc_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_OPA  = 2'd1,
        S_OPB  = 2'd2,
        S_DONE = 2'd3
    } opd_state_e;
endpackage

// File: rtl/opd_field_eval.sv
module opd_field_eval
    import opd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NR = NREG
) (
    input  logic [ACODE_W-1:0] code,
    input  logic               dest_pos,
    input  logic [NR*W-1:0]    regs,
    input  logic [W-1:0]       sp,
    input  logic [W-1:0]       pc,
    input  logic [W-1:0]       ex,
    input  logic [W-1:0]       nw,
    output opd_desc_t          desc,
    output logic [W-1:0]       sp_next,
    output logic               need_nw
);
    localparam int IW = $clog2(NR);

    logic [IW-1:0] ridx;
    logic [W-1:0]  rval;

    assign ridx = code[IW-1:0];
    assign rval = regs[ridx*W +: W];

    always_comb begin
        desc    = '0;
        sp_next = sp;
        need_nw = 1'b0;
        if (code[5]) begin
            desc.kind  = K_IMM;
            desc.value = W'(code[4:0]) - W'(1);
            desc.wr    = 1'b0;
        end else begin
            desc.wr = 1'b1;
            unique case (code[4:3])
                2'd0: begin
                    desc.kind  = K_REG;
                    desc.sel   = SEL_W'(ridx);
                    desc.value = rval;
                end
                2'd1: begin
                    desc.kind = K_MEM;
                    desc.addr = rval;
                end
                2'd2: begin
                    desc.kind = K_MEM;
                    desc.addr = nw + rval;
                    need_nw   = 1'b1;
                end
                default: begin
                    unique case (code[2:0])
                        3'd0: begin
                            desc.kind = K_MEM;
                            if (dest_pos) begin
                                sp_next   = sp - W'(1);
                                desc.addr = sp - W'(1);
                            end else begin
                                desc.addr = sp;
                                sp_next   = sp + W'(1);
                            end
                        end
                        3'd1: begin
                            desc.kind = K_MEM;
                            desc.addr = sp;
                        end
                        3'd2: begin
                            desc.kind = K_MEM;
                            desc.addr = sp + nw;
                            need_nw   = 1'b1;
                        end
                        3'd3: begin
                            desc.kind  = K_REG;
                            desc.sel   = SEL_SP;
                            desc.value = sp;
                        end
                        3'd4: begin
                            desc.kind  = K_REG;
                            desc.sel   = SEL_PC;
                            desc.value = pc;
                        end
                        3'd5: begin
                            desc.kind  = K_REG;
                            desc.sel   = SEL_EX;
                            desc.value = ex;
                        end
                        3'd6: begin
                            desc.kind = K_MEM;
                            desc.addr = nw;
                            need_nw   = 1'b1;
                        end
                        default: begin
                            desc.kind  = K_IMM;
                            desc.value = nw;
                            desc.wr    = 1'b0;
                            need_nw    = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/opd_special_decode.sv
module opd_special_decode
    import opd_pkg::*;
(
    input  logic [OP_W-1:0]    op,
    input  logic [BCODE_W-1:0] bcode,
    output logic               special,
    output logic               known
);
    always_comb begin
        special = (op == '0);
        known   = 1'b0;
        if (special) begin
            unique case (bcode)
                5'h01, 5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C,
                5'h10, 5'h11, 5'h12: known = 1'b1;
                default:             known = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/opd_resolver.sv
module opd_resolver
    import opd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [WORD_W-1:0]      instr,
    input  logic [NREG*WORD_W-1:0] regs_flat,
    input  logic [WORD_W-1:0]      sp_in,
    input  logic [WORD_W-1:0]      pc_in,
    input  logic [WORD_W-1:0]      ex_in,
    input  logic [WORD_W-1:0]      nw_data,
    input  logic                   nw_valid,
    output logic                   nw_req,
    output logic [WORD_W-1:0]      nw_addr,
    output logic                   done,
    output logic [OP_W-1:0]        opcode,
    output logic                   is_special,
    output logic [BCODE_W-1:0]     spec_op,
    output logic                   spec_known,
    output logic [1:0]             a_kind,
    output logic [SEL_W-1:0]       a_sel,
    output logic [WORD_W-1:0]      a_addr,
    output logic [WORD_W-1:0]      a_value,
    output logic                   a_wr,
    output logic                   b_used,
    output logic [1:0]             b_kind,
    output logic [SEL_W-1:0]       b_sel,
    output logic [WORD_W-1:0]      b_addr,
    output logic [WORD_W-1:0]      b_value,
    output logic                   b_wr,
    output logic [WORD_W-1:0]      sp_out,
    output logic [WORD_W-1:0]      pc_out
);
    localparam int NSLOT = 2;   // slot 0: a (source), slot 1: b (destination)

    typedef struct packed {
        opd_state_e                 state;
        logic [WORD_W-1:0]          word;
        logic [NREG*WORD_W-1:0]     regs;
        logic [WORD_W-1:0]          sp;
        logic [WORD_W-1:0]          pc;
        logic [WORD_W-1:0]          ex;
        opd_desc_t                  a;
        opd_desc_t                  b;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    logic [ACODE_W-1:0] slot_code [NSLOT];
    opd_desc_t          slot_desc [NSLOT];
    logic [WORD_W-1:0]  slot_sp   [NSLOT];
    logic               slot_need [NSLOT];
    logic               special_w;
    logic               known_w;

    assign slot_code[0] = ctx_q.word[15:10];
    assign slot_code[1] = {1'b0, ctx_q.word[9:5]};

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        opd_field_eval #(.W(WORD_W), .NR(NREG)) u_eval (
            .code     (slot_code[g]),
            .dest_pos (g == 1),
            .regs     (ctx_q.regs),
            .sp       (ctx_q.sp),
            .pc       (ctx_q.pc),
            .ex       (ctx_q.ex),
            .nw       (nw_data),
            .desc     (slot_desc[g]),
            .sp_next  (slot_sp[g]),
            .need_nw  (slot_need[g])
        );
    end

    opd_special_decode u_spec (
        .op      (ctx_q.word[4:0]),
        .bcode   (ctx_q.word[9:5]),
        .special (special_w),
        .known   (known_w)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.state)
            S_IDLE: begin
                if (start) begin
                    ctx_d.state = S_OPA;
                    ctx_d.word  = instr;
                    ctx_d.regs  = regs_flat;
                    ctx_d.sp    = sp_in;
                    ctx_d.pc    = pc_in;
                    ctx_d.ex    = ex_in;
                    ctx_d.a     = '0;
                    ctx_d.b     = '0;
                end
            end
            S_OPA: begin
                if (!slot_need[0] || nw_valid) begin
                    ctx_d.a  = slot_desc[0];
                    ctx_d.sp = slot_sp[0];
                    if (slot_need[0]) ctx_d.pc = ctx_q.pc + WORD_W'(1);
                    ctx_d.state = special_w ? S_DONE : S_OPB;
                end
            end
            S_OPB: begin
                if (!slot_need[1] || nw_valid) begin
                    ctx_d.b  = slot_desc[1];
                    ctx_d.sp = slot_sp[1];
                    if (slot_need[1]) ctx_d.pc = ctx_q.pc + WORD_W'(1);
                    ctx_d.state = S_DONE;
                end
            end
            default: ctx_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign nw_req     = ((ctx_q.state == S_OPA) && slot_need[0]) ||
                        ((ctx_q.state == S_OPB) && slot_need[1]);
    assign nw_addr    = ctx_q.pc;
    assign done       = (ctx_q.state == S_DONE);
    assign opcode     = ctx_q.word[4:0];
    assign is_special = special_w;
    assign spec_op    = ctx_q.word[9:5];
    assign spec_known = known_w;
    assign a_kind     = ctx_q.a.kind;
    assign a_sel      = ctx_q.a.sel;
    assign a_addr     = ctx_q.a.addr;
    assign a_value    = ctx_q.a.value;
    assign a_wr       = ctx_q.a.wr;
    assign b_used     = !special_w;
    assign b_kind     = ctx_q.b.kind;
    assign b_sel      = ctx_q.b.sel;
    assign b_addr     = ctx_q.b.addr;
    assign b_value    = ctx_q.b.value;
    assign b_wr       = ctx_q.b.wr;
    assign sp_out     = ctx_q.sp;
    assign pc_out     = ctx_q.pc;
endmodule

// File: rtl/opd_resolver_chk.sv
module opd_resolver_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        nw_req,
    input logic        nw_valid,
    input logic        done,
    input logic [1:0]  a_kind,
    input logic        a_wr,
    input logic [1:0]  b_kind,
    input logic        b_wr,
    input logic [15:0] sp_out,
    input logic [15:0] pc_out
);
    p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (sp_out == $past(sp_out) ||
                    sp_out == $past(sp_out) + 16'd1 ||
                    sp_out == $past(sp_out) - 16'd1));

    p_pc_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nw_req && nw_valid) |=> pc_out == $past(pc_out) + 16'd1);

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(nw_req && nw_valid)) |=> $stable(pc_out));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_not_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nw_req |-> !done);

    p_a_imm_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_kind == 2'd2) |-> !a_wr);

    p_b_imm_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_kind == 2'd2) |-> !b_wr);
endmodule

bind opd_resolver opd_resolver_chk u_opd_chk (.*);

// File: tb/tb_opd_resolver.sv
module tb_opd_resolver;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  instr = '0;
    logic [127:0] regs_flat = '0;
    logic [15:0]  sp_in = '0, pc_in = '0, ex_in = '0;
    logic [15:0]  nw_data = '0;
    logic         nw_valid = 1'b0;
    logic         nw_req, done, is_special, spec_known, a_wr, b_used, b_wr;
    logic [15:0]  nw_addr, a_addr, a_value, b_addr, b_value, sp_out, pc_out;
    logic [4:0]   opcode, spec_op;
    logic [1:0]   a_kind, b_kind;
    logic [3:0]   a_sel, b_sel;

    int checks = 0;
    int errors = 0;
    logic [15:0] rv [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    opd_resolver dut (.*);

    function automatic logic [15:0] mem_word(input logic [15:0] addr);
        return (addr * 16'h9E37) ^ 16'h5A5A;
    endfunction

    function automatic bit code_needs(input logic [5:0] c);
        return (c[5:3] == 3'd2) || (c == 6'h1A) || (c == 6'h1E) || (c == 6'h1F);
    endfunction

    function automatic string tag_of(input logic [5:0] c);
        if (c >= 6'h20) return "R7";
        if (c < 6'h10) return "R3";
        if (c < 6'h18 || c == 6'h1E || c == 6'h1F) return "R4";
        if (c == 6'h18) return "R5";
        return "R6";
    endfunction

    // Reference model of one operand, built from the requirements.
    // Packed result: {kind[1:0], sel[3:0], addr[15:0], value[15:0], wr}
    function automatic logic [38:0] model(input logic [5:0] c, input bit dest,
                                          inout logic [15:0] sp, input logic [15:0] pc,
                                          input logic [15:0] ex, input logic [15:0] nw);
        logic [1:0] k; logic [3:0] s; logic [15:0] ad, va; logic w;
        k = 0; s = 0; ad = 0; va = 0; w = 1;
        if (c >= 6'h20) begin k = 2; va = {11'd0, c[4:0]} - 16'd1; w = 0; end
        else if (c < 6'h08) begin k = 0; s = c[3:0]; va = rv[c[2:0]]; end
        else if (c < 6'h10) begin k = 1; ad = rv[c[2:0]]; end
        else if (c < 6'h18) begin k = 1; ad = nw + rv[c[2:0]]; end
        else begin
            case (c)
                6'h18: begin k = 1;
                    if (dest) begin sp = sp - 16'd1; ad = sp; end
                    else begin ad = sp; sp = sp + 16'd1; end end
                6'h19: begin k = 1; ad = sp; end
                6'h1A: begin k = 1; ad = sp + nw; end
                6'h1B: begin k = 0; s = 4'd8; va = sp; end
                6'h1C: begin k = 0; s = 4'd9; va = pc; end
                6'h1D: begin k = 0; s = 4'd10; va = ex; end
                6'h1E: begin k = 1; ad = nw; end
                default: begin k = 2; va = nw; w = 0; end
            endcase
        end
        return {k, s, ad, va, w};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] w, input logic [15:0] sp0,
                       input logic [15:0] pc0, input bit glitch);
        logic [15:0] sp, pc, ex0, nw, fa [2];
        logic [38:0] ea, eb;
        logic [5:0]  ac, bc;
        bit special;
        int nf, got, cyc;
        ac = w[15:10]; bc = {1'b0, w[9:5]}; special = (w[4:0] == 5'd0);
        for (int i = 0; i < 8; i++) rv[i] = 16'($urandom);
        ex0 = 16'($urandom);
        sp = sp0; pc = pc0; nf = 0; eb = '0;
        nw = 16'h0;
        if (code_needs(ac)) begin fa[nf] = pc; nw = mem_word(pc); pc++; nf++; end
        ea = model(ac, 1'b0, sp, pc, ex0, nw);
        if (!special) begin
            nw = 16'h0;
            if (code_needs(bc)) begin fa[nf] = pc; nw = mem_word(pc); pc++; nf++; end
            eb = model(bc, 1'b1, sp, pc, ex0, nw);
        end
        @(negedge clk);
        instr = w; sp_in = sp0; pc_in = pc0; ex_in = ex0;
        for (int i = 0; i < 8; i++) regs_flat[i*16 +: 16] = rv[i];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; instr = ~w; sp_in = ~sp0; pc_in = ~pc0;
        got = 0; cyc = 0;
        while (!done && cyc < 60) begin
            start = (glitch && cyc == 0);
            nw_valid = 1'b0;
            if (nw_req) begin
                chk("R8", "fetch address", {48'd0, nw_addr},
                    {48'd0, (got < nf) ? fa[got] : 16'hDEAD});
                if ($urandom % 3 != 0) begin
                    nw_valid = 1'b1; nw_data = mem_word(nw_addr); got++;
                end else nw_data = 16'($urandom);
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; nw_valid = 1'b0;
        chk("R9", "done reached", {63'd0, done}, 64'd1);
        chk("R1", "opcode", {59'd0, opcode}, {59'd0, w[4:0]});
        chk(tag_of(ac), "a descriptor", {25'd0, a_kind, a_sel, a_addr, a_value, a_wr},
            {25'd0, ea});
        chk("R8", "fetch count/pc", {got, pc_out}, {nf, pc});
        chk((ac == 6'h18 || bc == 6'h18) ? "R5" : "R8", "sp_out",
            {48'd0, sp_out}, {48'd0, sp});
        if (special) begin
            chk("R2", "special flags", {57'd0, is_special, spec_op, b_used},
                {57'd0, 1'b1, w[9:5], 1'b0});
            chk("R2", "special b zero", {25'd0, b_kind, b_sel, b_addr, b_value, b_wr}, 64'd0);
            chk("R2", "spec_known", {63'd0, spec_known},
                {63'd0, (w[9:5] == 5'h01 || (w[9:5] >= 5'h08 && w[9:5] <= 5'h0C) ||
                         (w[9:5] >= 5'h10 && w[9:5] <= 5'h12))});
        end else begin
            chk("R1", "not special", {62'd0, is_special, b_used}, 64'd1);
            chk(tag_of(bc), "b descriptor", {25'd0, b_kind, b_sel, b_addr, b_value, b_wr},
                {25'd0, eb});
        end
        @(negedge clk);
        chk("R9", "done single pulse", {63'd0, done}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R10", "reset outputs", {30'd0, done, nw_req, sp_out, pc_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "idle after reset", {62'd0, done, nw_req}, 64'd0);
        // every a code, b fixed to register A
        for (int c = 0; c < 64; c++) run({6'(c), 5'd0, 5'h01}, 16'h4000, 16'h0100, 1'b0);
        // every b code, a fixed to literal 0
        for (int c = 0; c < 32; c++) run({6'h21, 5'(c), 5'h02}, 16'h4000, 16'h0200, 1'b0);
        // every special opcode
        for (int c = 0; c < 32; c++) run({6'h1E, 5'(c), 5'h00}, 16'h1000, 16'h0300, 1'b0);
        // stack wraparound: push at 0x0000, pop at 0xFFFF, push after pop
        run({6'h00, 5'h18, 5'h01}, 16'h0000, 16'h0010, 1'b0);
        run({6'h18, 5'h00, 5'h01}, 16'hFFFF, 16'h0010, 1'b0);
        run({6'h18, 5'h18, 5'h01}, 16'h0000, 16'h0010, 1'b0);
        run({6'h18, 5'h1B, 5'h01}, 16'hFFFF, 16'h0010, 1'b0);
        // two fetches, a first; PC wraps; PC seen by b after a fetch
        run({6'h1F, 5'h10, 5'h01}, 16'h0100, 16'hFFFF, 1'b0);
        run({6'h1A, 5'h1E, 5'h03}, 16'hFFF0, 16'h0020, 1'b0);
        run({6'h1F, 5'h1C, 5'h01}, 16'h0100, 16'h0040, 1'b0);
        // start ignored while busy
        run({6'h1F, 5'h1A, 5'h04}, 16'h0800, 16'h0050, 1'b1);
        run({6'h03, 5'h02, 5'h05}, 16'h0800, 16'h0060, 1'b1);
        for (int i = 0; i < 300; i++)
            run(16'($urandom), 16'($urandom), 16'($urandom), ($urandom % 4) == 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule